// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Generator

This block derives the bit-rate timing of an asynchronous serial port from the internal bus clock. That bus clock runs at a quarter of the oscillator frequency. A 2-bit prescaler code picks one of four fixed divide ratios: 1, 3, 4 or 13. This sets the fastest bit rate the port can reach. A 3-bit rate code then divides that rate again by a power of two, from 1 to 128. The two stages run in series. Their combined output is the receive sampling rate, which is sixteen times the bit rate. A final divide-by-16 stage produces the transmit bit rate.

Every stage runs on the single bus clock. Each output is a clock-enable pulse one bus cycle wide, so no divided clock is ever generated. When either select code changes, the prescaler and power-of-two counters restart at once. The next sampling pulse therefore follows the new ratio, and no stale period is left to finish. The divide-by-16 counter is not restarted by a select change. Reset clears all counters. The select codes are inputs only, so reset neither stores nor alters them.

Top module: `baud_gen_top`

## Requirements
- R1: While rst_n is low, rx16_tick and tx1_tick are both 0. Reset clears every counter, so with prescale ratio P and rate ratio N, the first rx16_tick is high in bus cycle P*N after release. Cycle 1 is the cycle following the first rising edge after release.
- R2: The prescaler code on presc_sel selects the prescale ratio P: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R3: The rate code on rate_sel selects the rate ratio N = 2^rate_sel: 000 gives 1, and 111 gives 128.
- R4: With both codes held steady, rx16_tick is a single-cycle pulse that repeats exactly every P*N bus cycles.
- R5: tx1_tick is high only in a cycle where rx16_tick is also high. It is high on every 16th rx16_tick, so its period is 16*P*N cycles and its first pulse is in cycle 16*P*N after reset.
- R6: With presc_sel = 00 and rate_sel = 000, rx16_tick is high in every cycle from cycle 1 onward, and tx1_tick is high every 16th cycle.
- R7: Suppose presc_sel or rate_sel changes, and the new value is first seen at the rising edge that ends cycle c. Then rx16_tick is low in cycles c+1 through c+P*N, where P and N are the new ratios, and it is high in cycle c+1+P*N. The divide-by-16 count is kept across the change.
- R8: rx16_tick is never high in two consecutive cycles unless both codes select ratio 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 2 | Prescaler ratio code |
| rate_sel | input | RATE_W (3) | Power-of-two rate code |
| rx16_tick | output | 1 | One-cycle enable at sixteen times the bit rate |
| tx1_tick | output | 1 | One-cycle enable at the bit rate |

## Verification
The bench builds the block with its default parameters: a 3-bit rate code and an oversampling factor of 16. This configuration is small enough that all 32 combinations of prescaler and rate codes can be swept. For each combination, the bench follows the output from reset until the first transmit pulse. It checks every cycle against positions derived from P*N. This covers both the slowest path (ratio 13 × 128) and the fastest path (ratio 1 × 1). A separate run changes the codes in the middle of a stream. It checks the restart gap and confirms that the divide-by-16 count survives the change.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int PRE_RATIO_MAX = 13;
    localparam int PRE_CW        = $clog2(PRE_RATIO_MAX);

    function automatic int unsigned pre_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 3;
            2'b10:   return 4;
            default: return 13;
        endcase
    endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] code,
    output logic       tick
);
    typedef struct packed {
        logic [PRE_CW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PRE_CW-1:0] last;

    always_comb begin
        s_d  = s_q;
        last = PRE_CW'(pre_ratio(code) - 1);
        tick = !clr && (s_q.cnt >= last);
        if (clr || tick)
            s_d.cnt = '0;
        else
            s_d.cnt = s_q.cnt + PRE_CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/baud_rate_div.sv
module baud_rate_div #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [RATE_W-1:0] rsel,
    output logic              tick
);
    localparam int CW = (1 << RATE_W) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rate_state_t;

    rate_state_t   s_d, s_q;
    logic [CW-1:0] mask;

    always_comb begin
        s_d  = s_q;
        mask = (CW'(1) << rsel) - CW'(1);
        tick = en && !clr && ((s_q.cnt & mask) == mask);
        if (clr)
            s_d.cnt = '0;
        else if (en)
            s_d.cnt = (s_q.cnt + CW'(1)) & mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/baud_ovs_div.sv
module baud_ovs_div #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int OW = $clog2(OVS);

    typedef struct packed {
        logic [OW-1:0] cnt;
    } ovs_state_t;

    ovs_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = en && (s_q.cnt == OW'(OVS - 1));
        if (en)
            s_d.cnt = tick ? '0 : s_q.cnt + OW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top #(
    parameter int RATE_W = 3,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        presc_sel,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              rx16_tick,
    output logic              tx1_tick
);
    localparam int SW = 2 + RATE_W;

    typedef struct packed {
        logic [SW-1:0] sel;
        logic          armed;
        logic          rx;
        logic          tx;
    } top_state_t;

    top_state_t    s_d, s_q;
    logic [SW-1:0] sel_now;
    logic          sel_change;
    logic          pre_tick;
    logic          rate_tick;
    logic          ovs_tick;

    baud_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sel_change),
        .code  (presc_sel),
        .tick  (pre_tick)
    );

    baud_rate_div #(.RATE_W(RATE_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sel_change),
        .en    (pre_tick),
        .rsel  (rate_sel),
        .tick  (rate_tick)
    );

    baud_ovs_div #(.OVS(OVS)) u_ovs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (rate_tick),
        .tick  (ovs_tick)
    );

    always_comb begin
        sel_now    = {presc_sel, rate_sel};
        sel_change = s_q.armed && (sel_now != s_q.sel);
        s_d        = s_q;
        s_d.sel    = sel_now;
        s_d.armed  = 1'b1;
        s_d.rx     = rate_tick;
        s_d.tx     = ovs_tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx16_tick = s_q.rx;
    assign tx1_tick  = s_q.tx;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        presc_sel,
    input logic [RATE_W-1:0] rate_sel,
    input logic              rx16_tick,
    input logic              tx1_tick
);
    logic [RATE_W+1:0] prev_sel;
    logic [1:0]        steady;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_sel <= '0;
            steady   <= '0;
        end else begin
            prev_sel <= {presc_sel, rate_sel};
            if ({presc_sel, rate_sel} != prev_sel) steady <= '0;
            else if (steady != 2'd3)               steady <= steady + 2'd1;
        end
    end

    // R1: outputs quiet while reset is held
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> (!rx16_tick && !tx1_tick));

    // R5: a transmit pulse always coincides with a sampling pulse
    p_tx_with_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx1_tick |-> rx16_tick);

    // R6: both ratios 1 and settled gives a pulse every cycle
    p_div1_every_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (steady >= 2'd1 && presc_sel == 2'b00 && rate_sel == '0) |-> rx16_tick);

    // R7: the cycle after a code change carries no sampling pulse
    p_quiet_after_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({presc_sel, rate_sel} != $past({presc_sel, rate_sel})) |=> !rx16_tick);

    // R8: back-to-back pulses only with both ratios at 1
    p_no_double_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (steady >= 2'd2 && rx16_tick && $past(rx16_tick))
            |-> (presc_sel == 2'b00 && rate_sel == '0));
endmodule

bind baud_gen_top baud_gen_chk #(.RATE_W(RATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .presc_sel (presc_sel),
    .rate_sel  (rate_sel),
    .rx16_tick (rx16_tick),
    .tx1_tick  (tx1_tick)
);

// File: tb/sim_baud_gen_top.sv
`timescale 1ns/1ps
module sim_baud_gen_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] presc_sel = 2'b00;
    logic [2:0] rate_sel = 3'b000;
    logic       rx16_tick;
    logic       tx1_tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    baud_gen_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_sel (presc_sel),
        .rate_sel  (rate_sel),
        .rx16_tick (rx16_tick),
        .tx1_tick  (tx1_tick)
    );

    function automatic int exp_pre(input int code);
        if (code == 0) return 1;
        if (code == 1) return 3;
        if (code == 2) return 4;
        return 13;
    endfunction

    task automatic check(input string req, input int cyc, input logic act, input logic exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp);
        end
    endtask

    task automatic start(input int p, input int r);
        rst_n = 1'b0;
        presc_sel = 2'(p);
        rate_sel = 3'(r);
        repeat (2) @(negedge clk);
        // R1: quiet during reset
        check("R1", 0, rx16_tick, 1'b0, "rx during reset");
        check("R1", 0, tx1_tick, 1'b0, "tx during reset");
        rst_n = 1'b1;
    endtask

    task automatic sweep(input int p, input int r);
        int np;
        np = exp_pre(p) * (1 << r);
        start(p, r);
        for (int cyc = 1; cyc <= 16 * np + 1; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            // R2 R3 R4 R8 rx positions, R5 R6 tx positions, R1 first pulse at np
            check((p == 0 && r == 0) ? "R6" : "R4", cyc, rx16_tick,
                  (cyc % np) == 0, "rx16_tick");
            check("R5", cyc, tx1_tick, (cyc % (16 * np)) == 0, "tx1_tick");
        end
    endtask

    task automatic change_run();
        logic erx;
        start(1, 1);
        for (int cyc = 1; cyc <= 80; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (cyc <= 10) erx = (cyc % 6) == 0;
            else           erx = (cyc >= 15) && ((cyc - 15) % 4 == 0);
            check("R7", cyc, rx16_tick, erx, "rx16_tick after change");
            check("R7", cyc, tx1_tick, cyc == 71, "tx1_tick keeps count");
            if (cyc == 10) begin
                presc_sel = 2'b10;
                rate_sel = 3'b000;
            end
        end
    endtask

    initial begin
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 8; r++)
                sweep(p, r);
        change_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #950000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule